// File: doc/BRIEF.md
# Bridge Port Error Capture Unit

This block records the first bus error seen on one interface of a bus bridge and reports it to software. An external detector presents an error strobe together with the cause bits that describe the fault, the 64-bit faulting address, the 64-bit data beat and a 32-bit parity/attribute word. On the first error after the cause word is empty, all of these are frozen into capture registers. Later errors only add their bits to the cause word, so the captured context always belongs to the oldest unhandled fault.

A 32-bit register bus with a write strobe, a 3-bit word index and a combinational read port gives software access to everything. Software clears the cause bits it has handled by writing zeros to them. Writing back the bitwise complement of the value it read clears exactly the bits it saw, and leaves bits that arrived in the meantime set. Once the cause word is empty again, the capture registers take the next error. A per-bit enable mask selects which cause bits drive the level-sensitive summary interrupt.

A parameter selects one of two port flavours. The host-side flavour implements only the low 8 enable bits. The peripheral-bus flavour leaves enable bit 0 unimplemented and adds a second enable register for the system-error line, whose bit 0 is also unimplemented.

Top module: `ecr_unit`

## Requirements
- R1: After a synchronous reset every register reads zero and `irq` is low.
- R2: On a clock edge with `err_stb` high, every bit set in `err_bits` becomes set in the cause word (index 0). Bits already set stay set.
- R3: When `err_stb` is high, `err_bits` is nonzero and the cause word is all zeros, the address low/high (indices 2/3), data low/high (indices 4/5) and attribute (index 6) registers load `err_addr[31:0]`, `err_addr[63:32]`, `err_data[31:0]`, `err_data[63:32]` and `err_attr`. A strobe whose `err_bits` is zero captures nothing and sets nothing.
- R4: An error that arrives while the cause word is nonzero leaves all capture registers unchanged.
- R5: A write to the cause word clears each bit written as 0 and keeps each bit written as 1. Bits from an error in the same cycle are set regardless. The cause word never gains a bit without a strobe.
- R6: After software clears the cause word to zero, the next error is captured afresh.
- R7: `irq` is high exactly while some cause bit and the same enable bit (index 1) are both set. It follows register updates in the same cycle.
- R8: In the host flavour only enable bits 7:0 are writable. Writing 0xFFFFFFFF reads back 0x000000FF.
- R9: In the peripheral-bus flavour enable bit 0 always reads 0. Writing 0xFFFFFFFF reads back 0xFFFFFFFE.
- R10: Index 7 is the system-error enable register. In the peripheral-bus flavour bit 0 reads 0 and the other bits are writable. In the host flavour it always reads 0.
- R11: Writes to indices 2 to 6 are ignored, and reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| err_stb | input | 1 | Error event strobe |
| err_bits | input | 32 | Cause bits of the event |
| err_addr | input | 64 | Faulting address |
| err_data | input | 64 | Data beat of the faulting transfer |
| err_attr | input | 32 | Parity/attribute word |
| irq | output | 1 | Level summary interrupt |

## Verification
A stale or wrongly re-armed capture flag shows up at the read port on the first read of an address or data register after a second error. The register shows either the newer fault's context or an old one after re-arming. A cause word that merges writes and strobes in the wrong order shows a missing or lingering bit at index 0 one cycle after the edge. It also moves `irq` in that same cycle. A reference model tracks both port flavours on every clock and compares the read port and `irq` a quarter period after each edge, so any such divergence is reported in the cycle it first becomes visible.

// File: rtl/ecr_pkg.sv
package ecr_pkg;

    localparam int ECR_W              = 32;
    localparam int ECR_IDX_W          = 3;
    localparam int ECR_HOST_MASK_BITS = 8;

    typedef logic [ECR_W-1:0] word_t;

    typedef enum logic [0:0] {
        ECR_HOST_PORT = 1'b0,
        ECR_PCI_PORT  = 1'b1
    } ecr_variant_e;

    typedef enum logic [ECR_IDX_W-1:0] {
        IDX_CAUSE   = 3'd0,
        IDX_ENABLE  = 3'd1,
        IDX_ADDR_LO = 3'd2,
        IDX_ADDR_HI = 3'd3,
        IDX_DATA_LO = 3'd4,
        IDX_DATA_HI = 3'd5,
        IDX_ATTR    = 3'd6,
        IDX_SYSERR  = 3'd7
    } ecr_idx_e;

    typedef struct packed {
        word_t addr_hi;
        word_t addr_lo;
        word_t data_hi;
        word_t data_lo;
        word_t attr;
    } ecr_capture_t;

    // Writable bits of the interrupt enable register per flavour.
    function automatic word_t ecr_enable_impl(ecr_variant_e v);
        if (v == ECR_PCI_PORT)
            return {{(ECR_W-1){1'b1}}, 1'b0};
        return {{(ECR_W-ECR_HOST_MASK_BITS){1'b0}}, {ECR_HOST_MASK_BITS{1'b1}}};
    endfunction

    // Writable bits of the system-error enable register per flavour.
    function automatic word_t ecr_syserr_impl(ecr_variant_e v);
        if (v == ECR_PCI_PORT)
            return {{(ECR_W-1){1'b1}}, 1'b0};
        return '0;
    endfunction

endpackage

// File: rtl/ecr_cause_reg.sv
module ecr_cause_reg
    import ecr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_cause,
    input  word_t wdata,
    input  logic  err_stb,
    input  word_t err_bits,
    input  word_t enable_q,
    output word_t cause_q,
    output logic  capture_en,
    output logic  irq
);

    word_t cause_d;

    // Capture only on a real event into an empty cause word.
    assign capture_en = err_stb && (err_bits != '0) && (cause_q == '0);

    always_comb begin
        cause_d = cause_q;
        if (wr_cause)
            cause_d = cause_d & wdata;
        if (err_stb)
            cause_d = cause_d | err_bits;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cause_q <= '0;
        else
            cause_q <= cause_d;
    end

    assign irq = |(cause_q & enable_q);

endmodule

// File: rtl/ecr_capture.sv
module ecr_capture
    import ecr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               capture_en,
    input  logic [2*ECR_W-1:0] err_addr,
    input  logic [2*ECR_W-1:0] err_data,
    input  word_t              err_attr,
    output ecr_capture_t       cap_q
);

    ecr_capture_t cap_d;

    always_comb begin
        cap_d.addr_lo = err_addr[ECR_W-1:0];
        cap_d.addr_hi = err_addr[2*ECR_W-1:ECR_W];
        cap_d.data_lo = err_data[ECR_W-1:0];
        cap_d.data_hi = err_data[2*ECR_W-1:ECR_W];
        cap_d.attr    = err_attr;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cap_q <= '0;
        else if (capture_en)
            cap_q <= cap_d;
    end

endmodule

// File: rtl/ecr_enable_regs.sv
module ecr_enable_regs
    import ecr_pkg::*;
#(
    parameter ecr_variant_e VARIANT = ECR_HOST_PORT
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_enable,
    input  logic  wr_syserr,
    input  word_t wdata,
    output word_t enable_q,
    output word_t syserr_q
);

    localparam word_t EN_IMPL = ecr_enable_impl(VARIANT);
    localparam word_t SE_IMPL = ecr_syserr_impl(VARIANT);

    always_ff @(posedge clk) begin
        if (rst)
            enable_q <= '0;
        else if (wr_enable)
            enable_q <= wdata & EN_IMPL;
    end

    generate
        if (VARIANT == ECR_PCI_PORT) begin : g_syserr
            always_ff @(posedge clk) begin
                if (rst)
                    syserr_q <= '0;
                else if (wr_syserr)
                    syserr_q <= wdata & SE_IMPL;
            end
        end else begin : g_no_syserr
            logic unused_wr_syserr;
            assign unused_wr_syserr = wr_syserr;
            assign syserr_q = '0;
        end
    endgenerate

endmodule

// File: rtl/ecr_read_mux.sv
module ecr_read_mux
    import ecr_pkg::*;
(
    input  ecr_idx_e     idx,
    input  word_t        cause_q,
    input  word_t        enable_q,
    input  word_t        syserr_q,
    input  ecr_capture_t cap_q,
    output word_t        rdata
);

    always_comb begin
        unique case (idx)
            IDX_CAUSE:   rdata = cause_q;
            IDX_ENABLE:  rdata = enable_q;
            IDX_ADDR_LO: rdata = cap_q.addr_lo;
            IDX_ADDR_HI: rdata = cap_q.addr_hi;
            IDX_DATA_LO: rdata = cap_q.data_lo;
            IDX_DATA_HI: rdata = cap_q.data_hi;
            IDX_ATTR:    rdata = cap_q.attr;
            IDX_SYSERR:  rdata = syserr_q;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecr_unit.sv
module ecr_unit
    import ecr_pkg::*;
#(
    parameter ecr_variant_e VARIANT = ECR_HOST_PORT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ECR_IDX_W-1:0] bus_addr,
    input  logic [ECR_W-1:0]   bus_wdata,
    output logic [ECR_W-1:0]   bus_rdata,
    input  logic               err_stb,
    input  logic [ECR_W-1:0]   err_bits,
    input  logic [2*ECR_W-1:0] err_addr,
    input  logic [2*ECR_W-1:0] err_data,
    input  logic [ECR_W-1:0]   err_attr,
    output logic               irq
);

    ecr_idx_e     idx;
    word_t        cause_q;
    word_t        enable_q;
    word_t        syserr_q;
    ecr_capture_t cap_q;
    logic         capture_en;
    logic         wr_cause;
    logic         wr_enable;
    logic         wr_syserr;

    assign idx       = ecr_idx_e'(bus_addr);
    assign wr_cause  = bus_wr && (idx == IDX_CAUSE);
    assign wr_enable = bus_wr && (idx == IDX_ENABLE);
    assign wr_syserr = bus_wr && (idx == IDX_SYSERR);

    ecr_cause_reg u_cause (
        .clk        (clk),
        .rst        (rst),
        .wr_cause   (wr_cause),
        .wdata      (bus_wdata),
        .err_stb    (err_stb),
        .err_bits   (err_bits),
        .enable_q   (enable_q),
        .cause_q    (cause_q),
        .capture_en (capture_en),
        .irq        (irq)
    );

    ecr_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .capture_en (capture_en),
        .err_addr   (err_addr),
        .err_data   (err_data),
        .err_attr   (err_attr),
        .cap_q      (cap_q)
    );

    ecr_enable_regs #(.VARIANT(VARIANT)) u_enable (
        .clk       (clk),
        .rst       (rst),
        .wr_enable (wr_enable),
        .wr_syserr (wr_syserr),
        .wdata     (bus_wdata),
        .enable_q  (enable_q),
        .syserr_q  (syserr_q)
    );

    ecr_read_mux u_rmux (
        .idx      (idx),
        .cause_q  (cause_q),
        .enable_q (enable_q),
        .syserr_q (syserr_q),
        .cap_q    (cap_q),
        .rdata    (bus_rdata)
    );

endmodule

// File: rtl/ecr_unit_chk.sv
module ecr_unit_chk
    import ecr_pkg::*;
#(
    parameter ecr_variant_e VARIANT = ECR_HOST_PORT
) (
    input logic         clk,
    input logic         rst,
    input logic         err_stb,
    input word_t        err_bits,
    input logic         irq,
    input word_t        cause_q,
    input word_t        enable_q,
    input word_t        syserr_q,
    input ecr_capture_t cap_q
);

    localparam word_t EN_IMPL = ecr_enable_impl(VARIANT);

    // R2
    cause_set_chk: assert property (@(posedge clk) disable iff (rst)
        err_stb |=> ((cause_q & $past(err_bits)) == $past(err_bits)));

    // R4
    capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cause_q != '0) |=> $stable(cap_q));

    // R5
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        !err_stb |=> ((cause_q & ~$past(cause_q)) == '0));

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((cause_q & enable_q) != '0));

    // R8
    enable_impl_chk: assert property (@(posedge clk) disable iff (rst)
        (enable_q & ~EN_IMPL) == '0);

    // R10
    syserr_bit0_chk: assert property (@(posedge clk) disable iff (rst)
        syserr_q[0] == 1'b0);

endmodule

bind ecr_unit ecr_unit_chk #(.VARIANT(VARIANT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .err_stb  (err_stb),
    .err_bits (err_bits),
    .irq      (irq),
    .cause_q  (cause_q),
    .enable_q (enable_q),
    .syserr_q (syserr_q),
    .cap_q    (cap_q)
);

// File: tb/tb_ecr_unit.sv
module tb_ecr_unit;
    import ecr_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        err_stb = 1'b0;
    logic [31:0] err_bits = '0;
    logic [63:0] err_addr = '0;
    logic [63:0] err_data = '0;
    logic [31:0] err_attr = '0;
    logic [31:0] rdata_h, rdata_p;
    logic        irq_h, irq_p;

    int n_vec = 0;
    int n_mis = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecr_unit #(.VARIANT(ECR_HOST_PORT)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_h), .err_stb(err_stb),
        .err_bits(err_bits), .err_addr(err_addr), .err_data(err_data),
        .err_attr(err_attr), .irq(irq_h)
    );

    ecr_unit #(.VARIANT(ECR_PCI_PORT)) dut_pci (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_p), .err_stb(err_stb),
        .err_bits(err_bits), .err_addr(err_addr), .err_data(err_data),
        .err_attr(err_attr), .irq(irq_p)
    );

    // Reference model, index 0 = host flavour, 1 = peripheral-bus flavour
    logic [31:0] m_cause[2], m_en[2], m_se[2];
    logic [31:0] m_alo[2], m_ahi[2], m_dlo[2], m_dhi[2], m_attr[2];

    function automatic logic [31:0] en_bits(int v);
        return (v == 0) ? 32'h0000_00FF : 32'hFFFF_FFFE;   // R8 R9
    endfunction

    function automatic logic [31:0] se_bits(int v);
        return (v == 0) ? 32'h0 : 32'hFFFF_FFFE;           // R10
    endfunction

    function automatic logic [31:0] m_read(int v, logic [2:0] a);
        case (a)
            3'd0: return m_cause[v];
            3'd1: return m_en[v];
            3'd2: return m_alo[v];
            3'd3: return m_ahi[v];
            3'd4: return m_dlo[v];
            3'd5: return m_dhi[v];
            3'd6: return m_attr[v];
            default: return m_se[v];
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] a);
        case (a)
            3'd0: return "R5";
            3'd1: return "R8";
            3'd7: return "R10";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_vec++;
        if (got !== exp) begin
            n_mis++;
            $display("FAIL %s: got %08h expected %08h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        for (int v = 0; v < 2; v++) begin
            if (rst) begin
                m_cause[v] = '0; m_en[v] = '0; m_se[v] = '0;
                m_alo[v] = '0; m_ahi[v] = '0; m_dlo[v] = '0; m_dhi[v] = '0; m_attr[v] = '0;
            end else begin
                logic [31:0] nc;
                if (err_stb && err_bits != 0 && m_cause[v] == 0) begin
                    m_alo[v] = err_addr[31:0];  m_ahi[v] = err_addr[63:32];
                    m_dlo[v] = err_data[31:0];  m_dhi[v] = err_data[63:32];
                    m_attr[v] = err_attr;
                end
                nc = m_cause[v];
                if (bus_wr && bus_addr == 3'd0) nc = nc & bus_wdata;
                if (err_stb) nc = nc | err_bits;
                m_cause[v] = nc;
                if (bus_wr && bus_addr == 3'd1) m_en[v] = bus_wdata & en_bits(v);
                if (bus_wr && bus_addr == 3'd7) m_se[v] = bus_wdata & se_bits(v);
            end
        end
        #(CLK_PERIOD/4);
        if (!done) begin
            chk(rdata_h, m_read(0, bus_addr), tag_of(bus_addr));
            chk(rdata_p, m_read(1, bus_addr), tag_of(bus_addr));
            chk({31'b0, irq_h}, {31'b0, |(m_cause[0] & m_en[0])}, "R7");
            chk({31'b0, irq_p}, {31'b0, |(m_cause[1] & m_en[1])}, "R7");
        end
    end

    task automatic idle_pins();
        bus_wr = 1'b0; err_stb = 1'b0; err_bits = '0;
    endtask

    task automatic rd2(input logic [2:0] a, input logic [31:0] eh,
                       input logic [31:0] ep, input string tag);
        @(negedge clk);
        idle_pins();
        bus_addr = a;
        #1;
        chk(rdata_h, eh, tag);
        chk(rdata_p, ep, tag);
    endtask

    task automatic irq2(input logic eh, input logic ep, input string tag);
        @(negedge clk);
        idle_pins();
        #1;
        chk({31'b0, irq_h}, {31'b0, eh}, tag);
        chk({31'b0, irq_p}, {31'b0, ep}, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        idle_pins();
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic raise(input logic [31:0] bits, input logic [63:0] a,
                         input logic [63:0] d, input logic [31:0] at);
        @(negedge clk);
        idle_pins();
        err_stb = 1'b1; err_bits = bits; err_addr = a; err_data = d; err_attr = at;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd2(3'd0, 32'h0, 32'h0, "R1");
        rd2(3'd2, 32'h0, 32'h0, "R1");
        irq2(1'b0, 1'b0, "R1");
        // R8 R9 enable implemented bits
        wr(3'd1, 32'hFFFF_FFFF);
        rd2(3'd1, 32'h0000_00FF, 32'hFFFF_FFFE, "R8/R9");
        // R10 system-error enable
        wr(3'd7, 32'hFFFF_FFFF);
        rd2(3'd7, 32'h0, 32'hFFFF_FFFE, "R10");
        wr(3'd1, 32'h0000_0010);
        // R2 R3 first capture
        raise(32'h4, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, 32'h5A);
        rd2(3'd0, 32'h4, 32'h4, "R2");
        rd2(3'd2, 32'h3333_4444, 32'h3333_4444, "R3");
        rd2(3'd3, 32'h1111_2222, 32'h1111_2222, "R3");
        rd2(3'd4, 32'hCCCC_DDDD, 32'hCCCC_DDDD, "R3");
        rd2(3'd5, 32'hAAAA_BBBB, 32'hAAAA_BBBB, "R3");
        rd2(3'd6, 32'h5A, 32'h5A, "R3");
        irq2(1'b0, 1'b0, "R7 masked");
        // R4 second error does not overwrite
        raise(32'h10, 64'h5555_6666_7777_8888, 64'h0, 32'h1);
        rd2(3'd0, 32'h14, 32'h14, "R2");
        rd2(3'd2, 32'h3333_4444, 32'h3333_4444, "R4");
        rd2(3'd6, 32'h5A, 32'h5A, "R4");
        irq2(1'b1, 1'b1, "R7");
        // R11 capture registers ignore writes
        wr(3'd2, 32'hDEAD_BEEF);
        rd2(3'd2, 32'h3333_4444, 32'h3333_4444, "R11");
        rd2(3'd2, 32'h3333_4444, 32'h3333_4444, "R11 read twice");
        // R5 complement-of-read clear
        wr(3'd0, ~32'h10);
        rd2(3'd0, 32'h4, 32'h4, "R5");
        irq2(1'b0, 1'b0, "R7 cleared");
        wr(3'd0, ~32'h4);
        rd2(3'd0, 32'h0, 32'h0, "R5");
        // R6 re-armed capture
        raise(32'h1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 32'h33);
        rd2(3'd2, 32'h89AB_CDEF, 32'h89AB_CDEF, "R6");
        rd2(3'd5, 32'hFEDC_BA98, 32'hFEDC_BA98, "R6");
        rd2(3'd6, 32'h33, 32'h33, "R6");
        // R5 clear and error in the same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h0;
        err_stb = 1'b1; err_bits = 32'h2; err_addr = 64'h9999_9999_9999_9999;
        rd2(3'd0, 32'h2, 32'h2, "R5 simultaneous");
        rd2(3'd2, 32'h89AB_CDEF, 32'h89AB_CDEF, "R4");
        // R3 empty strobe captures nothing
        wr(3'd0, 32'h0);
        raise(32'h0, 64'h7777_7777_7777_7777, 64'h0, 32'h0);
        rd2(3'd0, 32'h0, 32'h0, "R3 empty");
        rd2(3'd2, 32'h89AB_CDEF, 32'h89AB_CDEF, "R3 empty");
        // Random phase against the model
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            idle_pins();
            bus_addr = 3'($urandom % 8);
            bus_wr = ($urandom % 4 == 0);
            bus_wdata = (bus_addr == 3'd0) ? ~(32'h1 << ($urandom % 8)) : $urandom;
            err_stb = ($urandom % 3 == 0);
            err_bits = (32'h1 << ($urandom % 8)) | (($urandom % 2) ? 32'h0 : 32'h80);
            err_addr = {$urandom, $urandom};
            err_data = {$urandom, $urandom};
            err_attr = $urandom;
        end
        @(negedge clk);
        idle_pins();
        @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_mis);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_mis++;
            $display("FAIL watchdog: run did not complete");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_mis);
            $finish;
        end
    end

endmodule